// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block sits between a simple register-style host port and an 8-bit NAND flash device. The host selects one of six registers per access. Writes to the command, address or data register each start one strobed bus cycle. A read of the data register starts a read cycle. The remaining registers (configuration, chip select, status) are read or written in a single clock, with no bus activity.

Every bus cycle has three phases, each with a programmable length in clock cycles. In the setup phase the latch-enable line and the outgoing byte settle. In the strobe phase the write or read strobe is held low. In the hold phase the strobe has returned high while the latch-enable line and data stay driven. A command byte is latched with the command latch line and an address byte with the address latch line. The chip enable is active low. A separate power-down input forces it inactive without disturbing the programmed select state. The device's ready/busy pin is synchronised and exposed as a status bit.

Top module: `nand_bus_sequencer`

## Requirements
- R1: After reset the host port is ready, chip enable is high (select bit reads 1), both latch lines are low, both strobes are high, the bus driver is off, and the configuration register reads every field at its maximum count minus one (0x0777 when the setup limit is 8).
- R2: The setup phase lasts (setup field + 1) clocks. The setup field sits at configuration bits [log2(SETUP_MAX)-1:0]. SETUP_MAX is 4 or 8.
- R3: The strobe phase lasts (strobe field + 1) clocks, with the strobe field at bits [6:4]. The hold phase lasts (hold field + 1) clocks, with the hold field at bits [10:8]. Each range is 1 to 8.
- R4: Writing register 2 (command) drives a bus cycle with the command latch high and the address latch low for the whole cycle. Writing register 3 (address) drives one with the address latch high and the command latch low. The two are never high together.
- R5: Writing register 4 (data) drives the written byte with the bus driver on and pulses the write strobe only. Reading register 4 pulses the read strobe only, with the bus driver off.
- R6: A data read captures the flash bus in the last clock of the strobe phase. The captured byte appears on the read-data port with the read-valid pulse in the first hold clock.
- R7: Bit 0 of register 1 is the select bit: 1 drives chip enable high (deselected) and 0 drives it low. It reads back.
- R8: While the power-down input is high, chip enable is high whatever the select bit holds. The select bit is unchanged, so chip enable returns to its prior level when the input falls.
- R9: Bit 0 of register 5 reads 1 when the ready/busy pin is high (ready) and 0 when it is low. The pin passes through a two-stage synchroniser.
- R10: Host ready is low for exactly the length of a bus cycle. A request held during that time is accepted after the cycle ends, and is neither lost nor overlapped with it.
- R11: Register 0 reads back only its field bits. Its fields can change only while the port is idle, so a running cycle keeps the lengths it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostReq | input | 1 | Host access request |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostSel | input | 3 | Register select (0 cfg, 1 select, 2 cmd, 3 addr, 4 data, 5 status) |
| hostWData | input | 16 | Host write data |
| hostReady | output | 1 | Port can accept an access this clock |
| hostRData | output | 16 | Host read data |
| hostRdValid | output | 1 | Read data valid pulse |
| sleepReq | input | 1 | Forces the chip enable inactive |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDout | output | DATA_W | Byte driven to the flash |
| nandDoe | output | 1 | Output enable for nandDout |
| nandDin | input | DATA_W | Byte read from the flash |
| nandRb | input | 1 | Ready/busy pin, 1 = ready |

## Verification
The bench builds the block with SETUP_MAX = 8, a strobe/hold limit of 8 and an 8-bit bus. With these values the full 8-clock setup phase can be reached and measured next to the 1-clock minimum. The reset configuration word then reads 0x0777. The default setup limit of 4 is covered only by elaboration of the field width. The bench changes the flash bus value on every strobe clock, so only a capture in the final strobe clock gives the expected byte.

// File: rtl/nandseq_pkg.sv
package nandseq_pkg;
  localparam int unsigned HOST_W = 16;

  localparam logic [2:0] REG_CFG  = 3'd0;
  localparam logic [2:0] REG_SEL  = 3'd1;
  localparam logic [2:0] REG_CMD  = 3'd2;
  localparam logic [2:0] REG_ADDR = 3'd3;
  localparam logic [2:0] REG_DATA = 3'd4;
  localparam logic [2:0] REG_STAT = 3'd5;

  localparam int unsigned STROBE_POS = 4;
  localparam int unsigned HOLD_POS   = 8;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;
  typedef enum logic [1:0] {CY_CMD, CY_ADDR, CY_WR, CY_RD} kind_e;

  typedef struct packed {
    logic   launch;
    logic   capture;
    logic   finish;
    phase_e phase;
    kind_e  kind;
  } seqStrobes_t;
endpackage

// File: rtl/nandseq_ctrl.sv
module nandseq_ctrl import nandseq_pkg::*; #(
  parameter int unsigned SETUP_W = 2,
  parameter int unsigned PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostReq,
  input  logic               hostWe,
  input  logic [2:0]         hostSel,
  input  logic [SETUP_W-1:0] cfgSetup,
  input  logic [PHASE_W-1:0] cfgStrobe,
  input  logic [PHASE_W-1:0] cfgHold,
  output logic               hostReady,
  output seqStrobes_t        strobes
);
  localparam int unsigned CNT_W = (SETUP_W > PHASE_W) ? SETUP_W : PHASE_W;

  phase_e             phase;
  kind_e              kind, kindNext;
  logic [CNT_W-1:0]   cnt;
  logic [PHASE_W-1:0] strobeLen, holdLen;
  logic               isBus, launch;

  assign hostReady = (phase == PH_IDLE);
  assign isBus  = (hostSel == REG_DATA) ||
                  (hostWe && (hostSel == REG_CMD || hostSel == REG_ADDR));
  assign launch = hostReq && hostReady && isBus;

  always_comb begin
    unique case (hostSel)
      REG_CMD:  kindNext = CY_CMD;
      REG_ADDR: kindNext = CY_ADDR;
      default:  kindNext = hostWe ? CY_WR : CY_RD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      kind      <= CY_CMD;
      cnt       <= '0;
      strobeLen <= '0;
      holdLen   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (launch) begin
          phase     <= PH_SETUP;
          kind      <= kindNext;
          cnt       <= CNT_W'(cfgSetup);
          strobeLen <= cfgStrobe;
          holdLen   <= cfgHold;
        end
        PH_SETUP: if (cnt == '0) begin
          phase <= PH_STROBE;
          cnt   <= CNT_W'(strobeLen);
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cnt == '0) begin
          phase <= PH_HOLD;
          cnt   <= CNT_W'(holdLen);
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cnt == '0) phase <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.launch  = launch;
    strobes.capture = (phase == PH_STROBE) && (cnt == '0) && (kind == CY_RD);
    strobes.finish  = (phase == PH_HOLD) && (cnt == '0);
    strobes.phase   = phase;
    strobes.kind    = kind;
  end

  p_launch_setup_r2: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> (phase == PH_SETUP));

  p_phase_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STROBE) |-> ($past(phase) == PH_SETUP || $past(phase) == PH_STROBE));

  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && !strobes.finish) |=>
      ($stable(kind) && $stable(strobeLen) && $stable(holdLen)));
endmodule

// File: rtl/nandseq_dp.sv
module nandseq_dp import nandseq_pkg::*; #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SETUP_MAX  = 4,
  parameter int unsigned PHASE_MAX  = 8,
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned SETUP_W    = 2,
  parameter int unsigned PHASE_W    = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostReq,
  input  logic               hostWe,
  input  logic [2:0]         hostSel,
  input  logic [HOST_W-1:0]  hostWData,
  input  logic               hostReady,
  input  seqStrobes_t        strobes,
  input  logic               sleepReq,
  input  logic [DATA_W-1:0]  nandDin,
  input  logic               nandRb,
  output logic [SETUP_W-1:0] cfgSetup,
  output logic [PHASE_W-1:0] cfgStrobe,
  output logic [PHASE_W-1:0] cfgHold,
  output logic [HOST_W-1:0]  hostRData,
  output logic               hostRdValid,
  output logic               nandCeN,
  output logic               nandCle,
  output logic               nandAle,
  output logic               nandWeN,
  output logic               nandReN,
  output logic [DATA_W-1:0]  nandDout,
  output logic               nandDoe
);
  localparam logic [SETUP_W-1:0] SETUP_RST = SETUP_W'(SETUP_MAX - 1);
  localparam logic [PHASE_W-1:0] PHASE_RST = PHASE_W'(PHASE_MAX - 1);

  logic                  selBit;
  logic [DATA_W-1:0]     outByte;
  logic [SYNC_DEPTH-1:0] rbSync;
  logic                  accept, active, inStrobe;
  logic [HOST_W-1:0]     cfgWord;

  assign accept  = hostReq && hostReady;
  assign cfgWord = HOST_W'(cfgSetup)
                 | (HOST_W'(cfgStrobe) << STROBE_POS)
                 | (HOST_W'(cfgHold) << HOLD_POS);

  generate
    if (SYNC_DEPTH > 1) begin : g_syncChain
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) rbSync <= '0;
        else       rbSync <= {rbSync[SYNC_DEPTH-2:0], nandRb};
    end else begin : g_syncSingle
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) rbSync <= '0;
        else       rbSync <= nandRb;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgSetup  <= SETUP_RST;
      cfgStrobe <= PHASE_RST;
      cfgHold   <= PHASE_RST;
      selBit    <= 1'b1;
      outByte   <= '0;
    end else if (accept && hostWe) begin
      unique case (hostSel)
        REG_CFG: begin
          cfgSetup  <= hostWData[0 +: SETUP_W];
          cfgStrobe <= hostWData[STROBE_POS +: PHASE_W];
          cfgHold   <= hostWData[HOLD_POS +: PHASE_W];
        end
        REG_SEL:                     selBit  <= hostWData[0];
        REG_CMD, REG_ADDR, REG_DATA: outByte <= hostWData[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRData   <= '0;
      hostRdValid <= 1'b0;
    end else begin
      hostRdValid <= 1'b0;
      if (strobes.capture) begin
        hostRData   <= HOST_W'(nandDin);
        hostRdValid <= 1'b1;
      end else if (accept && !hostWe && hostSel != REG_DATA) begin
        hostRdValid <= 1'b1;
        unique case (hostSel)
          REG_CFG:  hostRData <= cfgWord;
          REG_SEL:  hostRData <= HOST_W'(selBit);
          REG_STAT: hostRData <= HOST_W'(rbSync[SYNC_DEPTH-1]);
          default:  hostRData <= '0;
        endcase
      end
    end
  end

  assign active   = (strobes.phase != PH_IDLE);
  assign inStrobe = (strobes.phase == PH_STROBE);
  assign nandCle  = active && (strobes.kind == CY_CMD);
  assign nandAle  = active && (strobes.kind == CY_ADDR);
  assign nandWeN  = !(inStrobe && strobes.kind != CY_RD);
  assign nandReN  = !(inStrobe && strobes.kind == CY_RD);
  assign nandDoe  = active && (strobes.kind != CY_RD);
  assign nandDout = outByte;
  assign nandCeN  = selBit | sleepReq;

  p_excl_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  p_cle_ale_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  p_sleep_ce_r8: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |-> nandCeN);

  p_capture_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> hostRdValid);

  p_cfg_still_r11: assert property (@(posedge clk) disable iff (!rstN)
    !hostReady |=> $stable(cfgWord));
endmodule

// File: rtl/nand_bus_sequencer.sv
module nand_bus_sequencer import nandseq_pkg::*; #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SETUP_MAX  = 4,
  parameter int unsigned PHASE_MAX  = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [2:0]        hostSel,
  input  logic [15:0]       hostWData,
  output logic              hostReady,
  output logic [15:0]       hostRData,
  output logic              hostRdValid,
  input  logic              sleepReq,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [DATA_W-1:0] nandDout,
  output logic              nandDoe,
  input  logic [DATA_W-1:0] nandDin,
  input  logic              nandRb
);
  localparam int unsigned SETUP_W = (SETUP_MAX > 1) ? $clog2(SETUP_MAX) : 1;
  localparam int unsigned PHASE_W = (PHASE_MAX > 1) ? $clog2(PHASE_MAX) : 1;

  logic [SETUP_W-1:0] cfgSetup;
  logic [PHASE_W-1:0] cfgStrobe, cfgHold;
  seqStrobes_t        strobes;

  nandseq_ctrl #(.SETUP_W(SETUP_W), .PHASE_W(PHASE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .hostSel(hostSel), .cfgSetup(cfgSetup), .cfgStrobe(cfgStrobe),
    .cfgHold(cfgHold), .hostReady(hostReady), .strobes(strobes));

  nandseq_dp #(.DATA_W(DATA_W), .SETUP_MAX(SETUP_MAX), .PHASE_MAX(PHASE_MAX),
               .SYNC_DEPTH(SYNC_DEPTH), .SETUP_W(SETUP_W), .PHASE_W(PHASE_W)) u_dp (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .hostSel(hostSel), .hostWData(hostWData), .hostReady(hostReady),
    .strobes(strobes), .sleepReq(sleepReq), .nandDin(nandDin), .nandRb(nandRb),
    .cfgSetup(cfgSetup), .cfgStrobe(cfgStrobe), .cfgHold(cfgHold),
    .hostRData(hostRData), .hostRdValid(hostRdValid), .nandCeN(nandCeN),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandDout(nandDout), .nandDoe(nandDoe));
endmodule

// File: tb/sim_nand_bus_sequencer.sv
module sim_nand_bus_sequencer;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] kind;   // 0 cmd, 1 addr, 2 write, 3 read
    logic [2:0] su;
    logic [2:0] st;
    logic [2:0] ho;
    logic [7:0] val;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 3'd0, 3'd0, 3'd0, 8'hA5},
    '{2'd1, 3'd7, 3'd2, 3'd1, 8'h3C},
    '{2'd2, 3'd3, 3'd7, 3'd0, 8'h5A},
    '{2'd3, 3'd1, 3'd4, 3'd2, 8'h10},
    '{2'd3, 3'd0, 3'd0, 3'd0, 8'h80},
    '{2'd0, 3'd2, 3'd5, 3'd6, 8'hFF},
    '{2'd2, 3'd7, 3'd7, 3'd7, 8'h01},
    '{2'd3, 3'd7, 3'd7, 3'd7, 8'hE0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic hostReq = 1'b0, hostWe = 1'b0, sleepReq = 1'b0, nandRb = 1'b1;
  logic [2:0] hostSel = '0;
  logic [15:0] hostWData = '0;
  logic [7:0] nandDin = '0;
  logic hostReady, hostRdValid, nandCeN, nandCle, nandAle, nandWeN, nandReN, nandDoe;
  logic [15:0] hostRData;
  logic [7:0] nandDout;

  int checks = 0, failures = 0;
  bit finished = 0;

  // monitor state
  int suCnt = 0, stCnt = 0, hoCnt = 0, doneCnt = 0;
  int lastSu, lastSt, lastHo;
  bit mCle = 0, mAle = 0, mWe = 0, mRe = 0, mDoe = 0, busyPrev = 0;
  bit lastCle, lastAle, lastWe, lastRe, lastDoe;
  logic [7:0] mDout = '0, lastDout, dinBase = '0, lastRd = '0;
  logic [7:0] doneDout [4];
  int rdSeen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_bus_sequencer #(.DATA_W(8), .SETUP_MAX(8), .PHASE_MAX(8), .SYNC_DEPTH(2)) u0 (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe), .hostSel(hostSel),
    .hostWData(hostWData), .hostReady(hostReady), .hostRData(hostRData),
    .hostRdValid(hostRdValid), .sleepReq(sleepReq), .nandCeN(nandCeN),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandDout(nandDout), .nandDoe(nandDoe), .nandDin(nandDin), .nandRb(nandRb));

  always @(negedge clk) begin
    if (rstN) begin
      if (hostRdValid) begin lastRd = hostRData[7:0]; rdSeen++; end
      if (!hostReady) begin
        if (!nandWeN || !nandReN) begin
          nandDin = dinBase + 8'(stCnt);
          stCnt++;
          if (!nandWeN) begin mWe = 1; mDout = nandDout; end
          if (!nandReN) mRe = 1;
        end else if (stCnt == 0) suCnt++;
        else hoCnt++;
        mCle |= nandCle; mAle |= nandAle; mDoe |= nandDoe;
        busyPrev = 1;
      end else if (busyPrev) begin
        lastSu = suCnt; lastSt = stCnt; lastHo = hoCnt;
        lastCle = mCle; lastAle = mAle; lastWe = mWe; lastRe = mRe;
        lastDoe = mDoe; lastDout = mDout;
        doneDout[doneCnt % 4] = mDout;
        doneCnt++;
        suCnt = 0; stCnt = 0; hoCnt = 0;
        mCle = 0; mAle = 0; mWe = 0; mRe = 0; mDoe = 0; busyPrev = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [2:0] sel, input logic [15:0] wd,
                        output logic rdv, output logic [15:0] rdd);
    @(negedge clk);
    hostReq = 1; hostWe = we; hostSel = sel; hostWData = wd;
    while (!hostReady) @(negedge clk);
    @(negedge clk);
    rdv = hostRdValid; rdd = hostRData;
    hostReq = 0;
  endtask

  task automatic busCycle(input logic we, input logic [2:0] sel, input logic [15:0] wd);
    logic rdv; logic [15:0] rdd;
    int prev;
    prev = doneCnt;
    access(we, sel, wd, rdv, rdd);
    while (doneCnt == prev) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic rdv; logic [15:0] rdd;
    int prevRd;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(hostReady == 1, "R1 ready", hostReady, 1);
    check(nandCeN == 1 && nandCle == 0 && nandAle == 0, "R1 ce/latches",
          {nandCeN, nandCle, nandAle}, 3'b100);
    check(nandWeN == 1 && nandReN == 1 && nandDoe == 0, "R1 strobes",
          {nandWeN, nandReN, nandDoe}, 3'b110);
    access(0, 3'd0, 16'h0, rdv, rdd);
    check(rdv && rdd == 16'h0777, "R1 cfg reset", rdd, 16'h0777);
    access(0, 3'd1, 16'h0, rdv, rdd);
    check(rdv && rdd == 16'h0001, "R1 select reset", rdd, 1);
    // R1 default lengths: 8/8/8
    busCycle(1, 3'd2, 16'h0042);
    check(lastSu == 8 && lastSt == 8 && lastHo == 8, "R1 default phases",
          lastSu * 256 + lastSt * 16 + lastHo, 8 * 256 + 8 * 16 + 8);

    // table-driven cycles
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      logic [2:0] sel;
      v = VEC[i];
      access(1, 3'd0, 16'(v.su) | (16'(v.st) << 4) | (16'(v.ho) << 8), rdv, rdd);
      dinBase = v.val;
      prevRd = rdSeen;
      sel = (v.kind == 2'd0) ? 3'd2 : (v.kind == 2'd1) ? 3'd3 : 3'd4;
      busCycle(v.kind != 2'd3, sel, 16'(v.val));
      check(lastSu == int'(v.su) + 1, "R2 setup length", lastSu, int'(v.su) + 1);
      check(lastSt == int'(v.st) + 1, "R3 strobe length", lastSt, int'(v.st) + 1);
      check(lastHo == int'(v.ho) + 1, "R3 hold length", lastHo, int'(v.ho) + 1);
      check(lastCle == (v.kind == 2'd0) && lastAle == (v.kind == 2'd1), "R4 latch lines",
            {lastCle, lastAle}, {v.kind == 2'd0, v.kind == 2'd1});
      if (v.kind == 2'd3) begin
        check(!lastWe && lastRe && !lastDoe, "R5 read strobe", {lastWe, lastRe, lastDoe}, 3'b010);
        check(rdSeen == prevRd + 1 && lastRd == v.val + 8'(v.st), "R6 read capture",
              lastRd, v.val + 8'(v.st));
      end else begin
        check(lastWe && !lastRe && lastDoe && lastDout == v.val, "R5 write byte",
              lastDout, v.val);
      end
    end

    // R11 field readback
    access(1, 3'd0, 16'hFFFF, rdv, rdd);
    access(0, 3'd0, 16'h0, rdv, rdd);
    check(rdd == 16'h0777, "R11 field mask", rdd, 16'h0777);
    access(1, 3'd0, 16'h0352, rdv, rdd);
    access(0, 3'd0, 16'h0, rdv, rdd);
    check(rdd == 16'h0352, "R11 readback", rdd, 16'h0352);

    // R10 back-to-back request held through a cycle
    access(1, 3'd0, 16'h0121, rdv, rdd);
    begin
      int prev, lowCnt;
      prev = doneCnt; lowCnt = 0;
      @(negedge clk);
      hostReq = 1; hostWe = 1; hostSel = 3'd2; hostWData = 16'h00C1;
      while (!hostReady) @(negedge clk);
      @(negedge clk);
      hostWData = 16'h00C2;
      while (!hostReady) begin lowCnt++; @(negedge clk); end
      @(negedge clk);
      hostReq = 0;
      while (doneCnt < prev + 2) @(negedge clk);
      check(lowCnt == 2 + 3 + 2, "R10 stall length", lowCnt, 7);
      check(doneDout[prev % 4] == 8'hC1 && doneDout[(prev + 1) % 4] == 8'hC2,
            "R10 both bytes", {doneDout[prev % 4], doneDout[(prev + 1) % 4]}, 16'hC1C2);
    end

    // R7 / R8 chip enable
    access(1, 3'd1, 16'h0000, rdv, rdd);
    check(nandCeN == 0, "R7 select", nandCeN, 0);
    sleepReq = 1;
    @(negedge clk);
    check(nandCeN == 1, "R8 forced high", nandCeN, 1);
    access(0, 3'd1, 16'h0, rdv, rdd);
    check(rdd[0] == 0, "R8 select kept", rdd[0], 0);
    sleepReq = 0;
    @(negedge clk);
    check(nandCeN == 0, "R8 restored", nandCeN, 0);
    access(1, 3'd1, 16'h0001, rdv, rdd);
    check(nandCeN == 1, "R7 deselect", nandCeN, 1);

    // R9 ready/busy status
    nandRb = 0;
    repeat (3) @(negedge clk);
    access(0, 3'd5, 16'h0, rdv, rdd);
    check(rdv && rdd[0] == 0, "R9 busy", rdd[0], 0);
    nandRb = 1;
    repeat (3) @(negedge clk);
    access(0, 3'd5, 16'h0, rdv, rdd);
    check(rdv && rdd[0] == 1, "R9 ready", rdd[0], 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule